// File: doc/BRIEF.md
# Interrupt Raise/Acknowledge Controller

This block gathers interrupt causes for one device and presents them to the host as a single interrupt. Software sets cause bits by writing any 32-bit value to a raise register, and clears them by writing a mask to a separate acknowledge register (write one to clear). Sibling engines inside the device can also post causes: each presents a valid strobe with a 32-bit value, and every valid value is ORed into the same pending word. The pending word can be read back at any time.

The block drives two outputs. A level line stays high while any cause is pending. A single-cycle message pulse fires whenever causes are added. A mode bit selects one of the two, and the level line is the reset default. In message mode the pending word keeps its meaning, and the interrupt handler must still acknowledge it. If the handler does not, switching back to level mode raises the line at once.

Top module: `irq_aggregator`

## Requirements
- R1: After reset the pending word is 0, the mode is level, and irq_level, msg_pulse and rd_data are all 0.
- R2: A write to byte offset 0x60 (raise) ORs wr_data into the pending word. The new value is visible on the cycle after the write edge.
- R3: A write to byte offset 0x64 (acknowledge) clears from the pending word every bit that is 1 in wr_data. Bits that are 0 in wr_data are kept.
- R4: When a write and event strobes arrive in the same cycle, the next pending word is (pending & ~ack) | raise | events. A bit that is acknowledged and posted in the same cycle therefore stays set.
- R5: Each internal source i with evt_valid[i]=1 ORs evt_value[32*i+31:32*i] into the pending word. Sources without a valid strobe have no effect.
- R6: In level mode, irq_level is 1 exactly while the pending word is nonzero. It stays 1 until every bit has been acknowledged.
- R7: In message mode irq_level is 0. msg_pulse is 1 for exactly the one cycle after an edge at which the pending word gained at least one bit that was previously 0. This covers both a rise from zero and the addition of new bits to a nonzero word.
- R8: Pending bits are kept across mode changes and must be acknowledged in message mode too. Returning to level mode while bits are pending drives irq_level to 1.
- R9: Bit 0 of the mode register at byte offset 0x68 selects message mode when 1. The register reads back as that bit, with all other bits 0.
- R10: The pending word is read at byte offset 0x24. Reads of 0x60, 0x64 and unmapped offsets return 0. Writes to 0x24 and to unmapped offsets change nothing.
- R11: rd_data is registered. It is loaded on an edge where rd_en is 1, with the register state from before that edge, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write byte offset |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read byte offset |
| rd_data | output | 32 | Registered read data |
| evt_valid | input | NUM_SRC | Per-source event strobe |
| evt_value | input | 32*NUM_SRC | Per-source event value, source i in bits 32*i+31:32*i |
| irq_level | output | 1 | Level interrupt output |
| msg_pulse | output | 1 | Single-cycle message interrupt pulse |

## Verification
The hardest cases to reach are the overlaps in a single cycle. One is an acknowledge that clears a bit while an internal source posts that same bit. Another is a raise in message mode that only partly overlaps bits already pending, where the pulse must depend only on the bits that are new. The stimulus keeps the random values within a few low bits, so collisions between writes, events and pending bits happen often. Directed steps force the exact acknowledge-versus-event collision and a mode flip while bits are pending.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  localparam int REG_W = 32;

  localparam logic [7:0] OFS_PENDING = 8'h24;
  localparam logic [7:0] OFS_RAISE   = 8'h60;
  localparam logic [7:0] OFS_ACK     = 8'h64;
  localparam logic [7:0] OFS_MODE    = 8'h68;

  typedef enum logic {
    MODE_LEVEL = 1'b0,
    MODE_MSG   = 1'b1
  } irq_mode_e;

  typedef logic [REG_W-1:0] word_t;

  // Update rule for the pending word: clear acknowledged bits first, then add new causes.
  function automatic word_t pending_next(word_t cur, word_t ack, word_t raise, word_t evts);
    return (cur & ~ack) | raise | evts;
  endfunction

  // Bits that are set in the next value but not in the current one.
  function automatic word_t fresh_bits(word_t cur, word_t nxt);
    return nxt & ~cur;
  endfunction

endpackage

// File: rtl/irq_reg_if.sv
module irq_reg_if
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  word_t             wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  input  word_t             pending,
  output word_t             rd_data,
  output logic              raise_fire,
  output word_t             raise_val,
  output logic              ack_fire,
  output word_t             ack_val,
  output irq_mode_e         mode
);

  localparam logic [ADDR_W-1:0] A_PEND  = ADDR_W'(OFS_PENDING);
  localparam logic [ADDR_W-1:0] A_RAISE = ADDR_W'(OFS_RAISE);
  localparam logic [ADDR_W-1:0] A_ACK   = ADDR_W'(OFS_ACK);
  localparam logic [ADDR_W-1:0] A_MODE  = ADDR_W'(OFS_MODE);

  logic  mode_we;
  word_t rd_mux;

  assign raise_fire = wr_en && (wr_addr == A_RAISE);
  assign ack_fire   = wr_en && (wr_addr == A_ACK);
  assign mode_we    = wr_en && (wr_addr == A_MODE);
  assign raise_val  = raise_fire ? wr_data : '0;
  assign ack_val    = ack_fire   ? wr_data : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode <= MODE_LEVEL;
    else if (mode_we) mode <= irq_mode_e'(wr_data[0]);
  end

  always_comb begin
    rd_mux = '0;
    if (rd_addr == A_PEND)      rd_mux = pending;
    else if (rd_addr == A_MODE) rd_mux = word_t'(mode);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_data <= '0;
    else if (rd_en) rd_data <= rd_mux;
  end

endmodule

// File: rtl/irq_evt_merge.sv
module irq_evt_merge
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 3
) (
  input  logic [NUM_SRC-1:0]       evt_valid,
  input  logic [NUM_SRC*REG_W-1:0] evt_value,
  output word_t                    evt_bits,
  output logic                     evt_any
);

  word_t gated [NUM_SRC];

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    assign gated[g] = evt_valid[g] ? evt_value[g*REG_W +: REG_W] : '0;
  end

  always_comb begin
    evt_bits = '0;
    for (int i = 0; i < NUM_SRC; i++) evt_bits = evt_bits | gated[i];
  end

  assign evt_any = |evt_bits;

endmodule

// File: rtl/irq_pending.sv
module irq_pending
  import irq_agg_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  word_t ack_val,
  input  word_t raise_val,
  input  word_t evt_bits,
  output word_t pending,
  output logic  gained
);

  word_t nxt;

  assign nxt    = pending_next(pending, ack_val, raise_val, evt_bits);
  assign gained = |fresh_bits(pending, nxt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pending <= '0;
    else        pending <= nxt;
  end

endmodule

// File: rtl/irq_signal_gen.sv
module irq_signal_gen
  import irq_agg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  irq_mode_e mode,
  input  word_t     pending,
  input  logic      gained,
  output logic      irq_level,
  output logic      msg_pulse
);

  assign irq_level = (mode == MODE_LEVEL) && (pending != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) msg_pulse <= 1'b0;
    else        msg_pulse <= (mode == MODE_MSG) && gained;
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_SRC = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [ADDR_W-1:0]        wr_addr,
  input  logic [31:0]              wr_data,
  input  logic                     rd_en,
  input  logic [ADDR_W-1:0]        rd_addr,
  output logic [31:0]              rd_data,
  input  logic [NUM_SRC-1:0]       evt_valid,
  input  logic [NUM_SRC*32-1:0]    evt_value,
  output logic                     irq_level,
  output logic                     msg_pulse
);

  logic      raise_fire, ack_fire, evt_any, gained;
  word_t     raise_val, ack_val, evt_bits, pending;
  irq_mode_e mode;

  irq_reg_if #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .pending(pending),
    .rd_data(rd_data),
    .raise_fire(raise_fire), .raise_val(raise_val),
    .ack_fire(ack_fire), .ack_val(ack_val),
    .mode(mode)
  );

  irq_evt_merge #(.NUM_SRC(NUM_SRC)) u_merge (
    .evt_valid(evt_valid), .evt_value(evt_value),
    .evt_bits(evt_bits), .evt_any(evt_any)
  );

  irq_pending u_pend (
    .clk(clk), .rst_n(rst_n),
    .ack_val(ack_val), .raise_val(raise_val), .evt_bits(evt_bits),
    .pending(pending), .gained(gained)
  );

  irq_signal_gen u_sig (
    .clk(clk), .rst_n(rst_n),
    .mode(mode), .pending(pending), .gained(gained),
    .irq_level(irq_level), .msg_pulse(msg_pulse)
  );

endmodule

// File: rtl/irq_aggregator_sva.sv
module irq_aggregator_sva
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_en,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [31:0]       rd_data,
  input logic              raise_fire,
  input logic              ack_fire,
  input logic              evt_any,
  input word_t             raise_val,
  input word_t             ack_val,
  input word_t             pending,
  input irq_mode_e         mode,
  input logic              irq_level,
  input logic              msg_pulse
);

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    raise_fire |=> ((pending & $past(raise_val)) == $past(raise_val))); // R2

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_fire && !raise_fire && !evt_any) |=> ((pending & $past(ack_val)) == '0)); // R3

  AST_QUIET_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!raise_fire && !ack_fire && !evt_any) |=> $stable(pending)); // R5

  AST_LEVEL_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_LEVEL && pending != '0) |-> irq_level); // R6

  AST_MSG_NO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MODE_MSG) |-> !irq_level); // R7

  AST_PULSE_NEW_BITS: assert property (@(posedge clk) disable iff (!rst_n)
    msg_pulse |-> ((pending & ~$past(pending)) != '0)); // R7

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && (rd_addr == ADDR_W'(OFS_RAISE) || rd_addr == ADDR_W'(OFS_ACK))) |=> (rd_data == '0)); // R10

endmodule

bind irq_aggregator irq_aggregator_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
  .raise_fire(raise_fire), .ack_fire(ack_fire), .evt_any(evt_any),
  .raise_val(raise_val), .ack_val(ack_val), .pending(pending), .mode(mode),
  .irq_level(irq_level), .msg_pulse(msg_pulse)
);

// File: tb/irq_aggregator_test.sv
module irq_aggregator_test;

  localparam int NS = 3;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            wr_en = 1'b0, rd_en = 1'b0;
  logic [7:0]      wr_addr = '0, rd_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [31:0]     rd_data;
  logic [NS-1:0]   evt_valid = '0;
  logic [NS*32-1:0] evt_value = '0;
  logic            irq_level, msg_pulse;

  int compared = 0, mismatched = 0;
  logic [31:0] m_pend = '0;
  logic        m_msg = 1'b0;

  always #10 clk = ~clk;

  irq_aggregator uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .evt_valid(evt_valid), .evt_value(evt_value),
    .irq_level(irq_level), .msg_pulse(msg_pulse)
  );

  function automatic logic [31:0] read_model(logic [7:0] a, logic [31:0] p, logic m);
    if (a == 8'h24) return p;
    if (a == 8'h68) return {31'd0, m};
    return 32'd0;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // One cycle: drive at negedge, let the edge pass, check at the next negedge.
  task automatic step(logic we, logic [7:0] wa, logic [31:0] wd,
                      logic re, logic [7:0] ra,
                      logic [NS-1:0] ev, logic [NS*32-1:0] ed, string tag);
    logic [31:0] ack, rai, evs, nxt, rexp;
    logic        pul, nmode;
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra; evt_valid = ev; evt_value = ed;
    ack = (we && wa == 8'h64) ? wd : 32'd0;
    rai = (we && wa == 8'h60) ? wd : 32'd0;
    evs = '0;
    for (int i = 0; i < NS; i++) if (ev[i]) evs = evs | ed[i*32 +: 32];
    nxt   = (m_pend & ~ack) | rai | evs;
    pul   = m_msg && ((nxt & ~m_pend) != 0);
    nmode = (we && wa == 8'h68) ? wd[0] : m_msg;
    rexp  = read_model(ra, m_pend, m_msg);
    @(posedge clk);
    @(negedge clk);
    m_pend = nxt; m_msg = nmode;
    check({tag, " R6 irq_level"}, {31'd0, irq_level}, {31'd0, !m_msg && (m_pend != 0)});
    check({tag, " R7 msg_pulse"}, {31'd0, msg_pulse}, {31'd0, pul});
    if (re) check({tag, " R11 rd_data"}, rd_data, rexp);
  endtask

  task automatic idle(string tag);
    step(1'b0, 8'h0, 32'd0, 1'b0, 8'h0, '0, '0, tag);
  endtask

  task automatic rd_pend(string tag);
    step(1'b0, 8'h0, 32'd0, 1'b1, 8'h24, '0, '0, tag);
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    logic [7:0] addrs [5];
    addrs[0] = 8'h24; addrs[1] = 8'h60; addrs[2] = 8'h64; addrs[3] = 8'h68; addrs[4] = 8'h10;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    check("R1 irq_level", {31'd0, irq_level}, 32'd0);
    check("R1 msg_pulse", {31'd0, msg_pulse}, 32'd0);
    check("R1 rd_data", rd_data, 32'd0);
    rst_n = 1'b1;
    rd_pend("R1");
    step(1'b0, 8'h0, 32'd0, 1'b1, 8'h68, '0, '0, "R1 mode");

    // R2 raise, R3 ack
    step(1'b1, 8'h60, 32'h0000_0105, 1'b0, 8'h0, '0, '0, "R2");
    rd_pend("R2");
    check("R2 pending", rd_data, 32'h0000_0105);
    step(1'b1, 8'h64, 32'h0000_0101, 1'b0, 8'h0, '0, '0, "R3");
    rd_pend("R3");
    check("R3 pending", rd_data, 32'h0000_0004);

    // R10: writes to status and unmapped ignored; write-only reads return 0
    step(1'b1, 8'h24, 32'hFFFF_FFFF, 1'b1, 8'h60, '0, '0, "R10 wr status");
    check("R10 raise read", rd_data, 32'd0);
    step(1'b1, 8'h10, 32'hFFFF_FFFF, 1'b1, 8'h64, '0, '0, "R10 wr unmapped");
    check("R10 ack read", rd_data, 32'd0);
    rd_pend("R10");
    check("R10 pending unchanged", rd_data, 32'h0000_0004);

    // R4: ack and event hit the same bit in one cycle; R5 invalid source ignored
    step(1'b1, 8'h64, 32'h0000_0004, 1'b0, 8'h0, 3'b010,
         {32'hFFFF_0000, 32'h0000_0004, 32'h0000_0000}, "R4 R5");
    rd_pend("R4");
    check("R4 collision keeps bit", rd_data, 32'h0000_0004);
    step(1'b1, 8'h64, 32'hFFFF_FFFF, 1'b0, 8'h0, '0, '0, "R6 clear");
    check("R6 line low after ack", {31'd0, irq_level}, 32'd0);

    // R9/R7: message mode, new bits and repeated bits
    step(1'b1, 8'h68, 32'h0000_0003, 1'b1, 8'h68, '0, '0, "R9");
    step(1'b0, 8'h0, 32'd0, 1'b1, 8'h68, '0, '0, "R9 readback");
    check("R9 mode reads 1", rd_data, 32'd1);
    step(1'b1, 8'h60, 32'h0000_0010, 1'b0, 8'h0, '0, '0, "R7 rise");
    check("R7 pulse on rise", {31'd0, msg_pulse}, 32'd1);
    idle("R7 single");
    check("R7 pulse one cycle", {31'd0, msg_pulse}, 32'd0);
    step(1'b1, 8'h60, 32'h0000_0010, 1'b0, 8'h0, '0, '0, "R7 repeat");
    check("R7 no pulse same bits", {31'd0, msg_pulse}, 32'd0);
    step(1'b0, 8'h0, 32'd0, 1'b0, 8'h0, 3'b001, {64'd0, 32'h0000_0030}, "R7 add");
    check("R7 pulse on added bit", {31'd0, msg_pulse}, 32'd1);
    // R8: back to level with bits pending
    step(1'b1, 8'h68, 32'h0000_0000, 1'b0, 8'h0, '0, '0, "R8");
    check("R8 level rises", {31'd0, irq_level}, 32'd1);

    // Random phase
    for (int n = 0; n < 3000; n++) begin
      logic [NS*32-1:0] ed;
      logic [NS-1:0] ev;
      ed = '0;
      for (int i = 0; i < NS; i++) ed[i*32 +: 32] = $urandom & 32'h0000_00FF;
      ev = ($urandom % 4 == 0) ? NS'($urandom) : '0;
      step(($urandom % 2) == 1, addrs[$urandom % 5], $urandom & 32'h0000_00FF,
           ($urandom % 2) == 1, addrs[$urandom % 5], ev, ed, "RND R2 R3 R4");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule